// File: doc/BRIEF.md
# I/O Port Trap with Interrupt Steering

This block emulates a pair of legacy I/O ports. A small configuration file, reached through an index/data port, holds an activate flag, a 16-bit base address stored as two bytes, and a routing byte. The base selects an aligned 8-byte window on a simple I/O bus. Two bytes of that window, at offsets 0 and 4, are trapped ports. The other six bytes are ignored.

A write to a trapped port stores the byte in that port's latch. While the device is active and the port's routing nibble is non-zero, the write also sets a pending flag. The pending flag drives one line of a 16-line interrupt vector, and the nibble value picks the line. Software services the trap by reading the same port. The read returns the stored byte and drops the pending flag.

Top module: `port_trap_irq`

## Requirements
- R1: After reset, config index 30h reads 00h, 60h reads 00h, 61h reads 60h and 70h reads 00h, so the base is 0060h. irq_out is 0000h.
- R2: `cfg_rdata` shows the register selected by `cfg_index` in the same cycle. A write with `cfg_we` takes effect at the clock edge.
  - Index 30h keeps only bit 0, the active flag. Its bits 7:1 read 0.
  - Index 60h is the base high byte and index 61h is the base low byte.
  - Index 70h is the routing byte.
  - Every other index reads 00h, and writes to it are dropped.
- R3: An I/O access hits port A when `io_addr[15:3]` equals `base[15:3]` and `io_addr[2:0]` is 0. It hits port B under the same window match when `io_addr[2:0]` is 4. A read that hits while the device is active raises `io_rdata_en` in the same cycle.
- R4: An access at window offsets 1–3 or 5–7, or outside the window, changes no latch and no pending flag. It keeps `io_rdata_en` low, and `io_rdata` reads 00h whenever `io_rdata_en` is low.
- R5: Routing bits 3:0 steer port A and bits 7:4 steer port B. A nibble value n from 1 to 15 drives `irq_out[n]` while that port is pending. A value of 0 drives no line, so `irq_out[0]` is never high. The line follows the current nibble value.
- R6: A write that hits a port sets that port's pending flag at the edge, but only when the device is active and the port's nibble is non-zero. The flag holds until it is cleared.
- R7: While the device is inactive, port accesses change no latch and no pending flag, and reads are not driven.
- R8: An active read of a port returns that port's latched byte on `io_rdata` in the same cycle. It clears that port's pending flag at the edge.
- R9: When both nibbles name the same line, that line is high while either port is pending.
- R10: A read and a write that hit the same port in one cycle behave as follows:
  - The read returns the old byte.
  - The new byte is latched.
  - Setting the pending flag takes priority over clearing it.
- R11: An active write that hits a port latches its byte even when that port's nibble is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_index | input | 8 | Config register index |
| cfg_wdata | input | 8 | Config write byte |
| cfg_we | input | 1 | Config write strobe |
| cfg_rdata | output | 8 | Config read byte for `cfg_index` |
| io_addr | input | 16 | I/O bus address |
| io_wdata | input | 8 | I/O write byte |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_rdata | output | 8 | I/O read byte, 00h when not driven |
| io_rdata_en | output | 1 | Block drives the read data |
| irq_out | output | 16 | Interrupt lines 0 to 15 |

## Verification
Setting a pending flag by a write and clearing it by a read can land on the same port in the same clock. A configuration write can also retarget the routing, or deactivate the device, in the same cycle as a trapping write. The bench forces the same-port read-plus-write case with a directed sequence. Its random mix also strobes read, write and config write together, with addresses biased into the current window.

Each cycle's outcome is judged by a bench model that applies every action against the pre-edge configuration. The model gives set priority over clear. The bench then compares the returned byte, the read-enable and the interrupt vector against the model.

// File: rtl/port_trap_pkg.sv
// Shared constants for the I/O port trap: config register indices and
// the reset base address. Assumes an 8-bit config index space.
package port_trap_pkg;
    localparam logic [7:0]  IDX_ACTIVE  = 8'h30;
    localparam logic [7:0]  IDX_BASE_HI = 8'h60;
    localparam logic [7:0]  IDX_BASE_LO = 8'h61;
    localparam logic [7:0]  IDX_ROUTE   = 8'h70;
    localparam logic [15:0] BASE_RESET  = 16'h0060;
endpackage

// File: rtl/pt_cfg_regs.sv
// Configuration register file reached by index/data access.
// Holds the active flag, the base (high and low bytes) and the routing byte.
// Assumes a single-cycle write strobe; reads are combinational.
module pt_cfg_regs
    import port_trap_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ROUTE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         cfg_index,
    input  logic [7:0]         cfg_wdata,
    input  logic               cfg_we,
    output logic [7:0]         cfg_rdata,
    output logic               active,
    output logic [ADDR_W-1:0]  base,
    output logic [ROUTE_W-1:0] route
);
    logic [7:0] base_hi_q, base_lo_q;

    // Register update on config writes; unknown indices are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            base_hi_q <= BASE_RESET[15:8];
            base_lo_q <= BASE_RESET[7:0];
            route     <= '0;
        end else if (cfg_we) begin
            case (cfg_index)
                IDX_ACTIVE:  active    <= cfg_wdata[0];
                IDX_BASE_HI: base_hi_q <= cfg_wdata;
                IDX_BASE_LO: base_lo_q <= cfg_wdata;
                IDX_ROUTE:   route     <= cfg_wdata[ROUTE_W-1:0];
                default: ;
            endcase
        end
    end

    // Read mux of the indexed register; reserved bits read zero.
    always_comb begin
        case (cfg_index)
            IDX_ACTIVE:  cfg_rdata = {7'b0, active};
            IDX_BASE_HI: cfg_rdata = base_hi_q;
            IDX_BASE_LO: cfg_rdata = base_lo_q;
            IDX_ROUTE:   cfg_rdata = 8'(route);
            default:     cfg_rdata = 8'h00;
        endcase
    end

    assign base = ADDR_W'({base_hi_q, base_lo_q});
endmodule

// File: rtl/pt_window_decode.sv
// Window decoder: matches the aligned window selected by the base and
// flags which trapped port (at a fixed stride inside the window) is hit.
// Assumes WIN_BYTES is a power of two and ports fit in the window.
module pt_window_decode #(
    parameter int ADDR_W      = 16,
    parameter int WIN_BYTES   = 8,
    parameter int PORT_STRIDE = 4,
    parameter int NUM_PORTS   = 2
) (
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic [ADDR_W-1:0]    base,
    input  logic                 active,
    output logic [NUM_PORTS-1:0] hit
);
    localparam int OFF_W = $clog2(WIN_BYTES);

    logic win_match;

    // Upper address bits compare against the base; low bits are the offset.
    assign win_match = active && (io_addr[ADDR_W-1:OFF_W] == base[ADDR_W-1:OFF_W]);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_hit
        localparam logic [OFF_W-1:0] PORT_OFF = OFF_W'(p * PORT_STRIDE);
        // Exact offset match for this trapped port.
        assign hit[p] = win_match && (io_addr[OFF_W-1:0] == PORT_OFF);
    end
endmodule

// File: rtl/pt_trap_port.sv
// One trapped port: a data latch and a pending flag.
// Write hit latches the byte and sets pending when routed; read hit clears
// pending. Set wins over clear when both happen in one cycle.
module pt_trap_port #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic [SEL_W-1:0]  sel,
    output logic              pend,
    output logic [DATA_W-1:0] data
);
    logic wr_hit, rd_hit;

    assign wr_hit = hit && io_wr;
    assign rd_hit = hit && io_rd;

    // Latch the written byte on any write hit.
    always_ff @(posedge clk) begin
        if (!rst_n)      data <= '0;
        else if (wr_hit) data <= io_wdata;
    end

    // Pending flag: routed write sets, read clears, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                        pend <= 1'b0;
        else if (wr_hit && (sel != '0))    pend <= 1'b1;
        else if (rd_hit)                   pend <= 1'b0;
    end
endmodule

// File: rtl/pt_irq_steer.sv
// Steers each pending port onto the interrupt line named by its nibble.
// Nibble 0 routes nowhere; shared lines are OR-combined.
module pt_irq_steer #(
    parameter int NUM_PORTS = 2,
    parameter int IRQ_LINES = 16,
    parameter int SEL_W     = $clog2(IRQ_LINES)
) (
    input  logic [NUM_PORTS-1:0]       pend,
    input  logic [NUM_PORTS*SEL_W-1:0] sel,
    output logic [IRQ_LINES-1:0]       irq_out
);
    // OR every routed pending source into its selected line.
    always_comb begin
        irq_out = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (pend[p] && (sel[p*SEL_W +: SEL_W] != '0))
                irq_out[sel[p*SEL_W +: SEL_W]] = 1'b1;
        end
    end
endmodule

// File: rtl/port_trap_irq.sv
// Top of the I/O port trap: config file, window decode, two trapped ports
// and interrupt steering. Assumes one I/O access per cycle; read data is
// combinational and zero when the block does not drive it.
module port_trap_irq #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int IRQ_LINES   = 16,
    parameter int NUM_PORTS   = 2,
    parameter int WIN_BYTES   = 8,
    parameter int PORT_STRIDE = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           cfg_index,
    input  logic [7:0]           cfg_wdata,
    input  logic                 cfg_we,
    output logic [7:0]           cfg_rdata,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic [DATA_W-1:0]    io_wdata,
    input  logic                 io_wr,
    input  logic                 io_rd,
    output logic [DATA_W-1:0]    io_rdata,
    output logic                 io_rdata_en,
    output logic [IRQ_LINES-1:0] irq_out
);
    localparam int SEL_W   = $clog2(IRQ_LINES);
    localparam int ROUTE_W = NUM_PORTS * SEL_W;

    logic                 act_q;
    logic [ADDR_W-1:0]    base_v;
    logic [ROUTE_W-1:0]   sel_v;
    logic [NUM_PORTS-1:0] hit_v;
    logic [NUM_PORTS-1:0] pend_v;
    logic [DATA_W-1:0]    data_v [NUM_PORTS];

    pt_cfg_regs #(.ADDR_W(ADDR_W), .ROUTE_W(ROUTE_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_index(cfg_index), .cfg_wdata(cfg_wdata), .cfg_we(cfg_we),
        .cfg_rdata(cfg_rdata), .active(act_q), .base(base_v), .route(sel_v)
    );

    pt_window_decode #(
        .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES),
        .PORT_STRIDE(PORT_STRIDE), .NUM_PORTS(NUM_PORTS)
    ) u_dec (
        .io_addr(io_addr), .base(base_v), .active(act_q), .hit(hit_v)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        pt_trap_port #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_port (
            .clk(clk), .rst_n(rst_n), .hit(hit_v[p]),
            .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
            .sel(sel_v[p*SEL_W +: SEL_W]),
            .pend(pend_v[p]), .data(data_v[p])
        );
    end

    pt_irq_steer #(.NUM_PORTS(NUM_PORTS), .IRQ_LINES(IRQ_LINES), .SEL_W(SEL_W)) u_steer (
        .pend(pend_v), .sel(sel_v), .irq_out(irq_out)
    );

    // Read-back mux: drive only on a read that hits a trapped port.
    always_comb begin
        io_rdata    = '0;
        io_rdata_en = io_rd && (|hit_v);
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (io_rd && hit_v[p]) io_rdata = io_rdata | data_v[p];
        end
    end
endmodule

// File: rtl/pt_checker.sv
// Assertion checker for port_trap_irq, attached by bind below.
// Observes ports plus the active flag, hits, pending flags and routing.
module pt_checker #(
    parameter int ADDR_W    = 16,
    parameter int IRQ_LINES = 16,
    parameter int NUM_PORTS = 2,
    parameter int ROUTE_W   = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    io_addr,
    input logic                 io_wr,
    input logic                 io_rd,
    input logic                 io_rdata_en,
    input logic [IRQ_LINES-1:0] irq_out,
    input logic                 active,
    input logic [NUM_PORTS-1:0] hit,
    input logic [NUM_PORTS-1:0] pend,
    input logic [ROUTE_W-1:0]   sel
);
    // R4: read data is only driven at trapped offsets 0 and 4.
    a_r4_offset_silent: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata_en |-> (io_rd && (io_addr[2:0] == 3'd0 || io_addr[2:0] == 3'd4)));

    // R5: line 0 is never raised.
    a_r5_line0_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out[0]);

    // R7: no pending flag rises while inactive.
    a_r7_inactive_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> ((pend & ~$past(pend)) == '0));

    // R6: routed write hit on port A sets its pending flag.
    a_r6_port_a_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && hit[0] && sel[3:0] != 4'd0) |=> pend[0]);

    // R8: read-only hit on port B clears its pending flag.
    a_r8_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && hit[1]) |=> !pend[1]);

    // R9: at most one line per port.
    a_r9_line_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_out) <= NUM_PORTS);
endmodule

bind port_trap_irq pt_checker #(
    .ADDR_W(ADDR_W), .IRQ_LINES(IRQ_LINES), .NUM_PORTS(NUM_PORTS), .ROUTE_W(ROUTE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_rdata_en(io_rdata_en), .irq_out(irq_out), .active(act_q),
    .hit(hit_v), .pend(pend_v), .sel(sel_v)
);

// File: tb/port_trap_irq_test.sv
// Self-checking bench: directed corners plus seeded random traffic,
// compared each cycle against a bench-side model of the requirements.
module port_trap_irq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_index = '0, cfg_wdata = '0, cfg_rdata;
    logic        cfg_we = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0, io_rdata;
    logic        io_wr = 1'b0, io_rd = 1'b0, io_rdata_en;
    logic [15:0] irq_out;

    int total = 0, bad = 0;
    bit finished = 0;

    // Model state
    bit         m_en;
    bit [15:0]  m_base;
    bit [7:0]   m_sel;
    bit [1:0]   m_pend;
    bit [7:0]   m_dat [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    port_trap_irq uut (
        .clk(clk), .rst_n(rst_n), .cfg_index(cfg_index), .cfg_wdata(cfg_wdata),
        .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .io_rdata_en(io_rdata_en), .irq_out(irq_out)
    );

    function automatic void check(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endfunction

    function automatic void model_reset();
        m_en = 0; m_base = 16'h0060; m_sel = 0; m_pend = 0;
        m_dat[0] = 0; m_dat[1] = 0;
    endfunction

    function automatic int port_of(logic [15:0] a);
        if (!m_en || a[15:3] != m_base[15:3]) return -1;
        if (a[2:0] == 3'd0) return 0;
        if (a[2:0] == 3'd4) return 1;
        return -1;
    endfunction

    function automatic logic [15:0] exp_irq();
        logic [15:0] v = '0;
        for (int p = 0; p < 2; p++) begin
            logic [3:0] n = m_sel[p*4 +: 4];
            if (m_pend[p] && n != 0) v[n] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [7:0] exp_cfg(logic [7:0] idx);
        case (idx)
            8'h30: return {7'b0, m_en};
            8'h60: return m_base[15:8];
            8'h61: return m_base[7:0];
            8'h70: return m_sel;
            default: return 8'h00;
        endcase
    endfunction

    // One bus cycle: drive at negedge, check outputs, update model at posedge.
    task automatic cyc(bit cwe, logic [7:0] idx, logic [7:0] cw,
                       bit wr, bit rd, logic [15:0] a, logic [7:0] wd);
        int p;
        string tg;
        @(negedge clk);
        cfg_we = cwe; cfg_index = idx; cfg_wdata = cw;
        io_wr = wr; io_rd = rd; io_addr = a; io_wdata = wd;
        #1;
        p = port_of(a);
        if (a[15:3] == m_base[15:3] && a[2:0] != 0 && a[2:0] != 4) tg = "R4";
        else if (!m_en) tg = "R7";
        else if (p >= 0 && wr && rd) tg = "R10";
        else if (p >= 0 && m_sel[p*4 +: 4] == 0) tg = "R11";
        else tg = "R8";
        check("R3 rdata_en", {15'b0, io_rdata_en}, {15'b0, (rd && p >= 0)});
        check(tg, {8'b0, io_rdata}, (rd && p >= 0) ? {8'b0, m_dat[p]} : 16'h0);
        check("R5 R6 R9 irq", irq_out, exp_irq());
        check("R2 cfg", {8'b0, cfg_rdata}, {8'b0, exp_cfg(idx)});
        @(posedge clk);
        if (p >= 0) begin
            if (wr) m_dat[p] = wd;
            if (wr && m_sel[p*4 +: 4] != 0) m_pend[p] = 1;
            else if (rd) m_pend[p] = 0;
        end
        if (cwe) begin
            case (idx)
                8'h30: m_en = cw[0];
                8'h60: m_base[15:8] = cw;
                8'h61: m_base[7:0] = cw;
                8'h70: m_sel = cw;
                default: ;
            endcase
        end
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset values of each register and the interrupt vector.
        foreach (v[i]) ;
        cyc(0, 8'h30, 0, 0, 0, 0, 0); check("R1 act", {8'b0, cfg_rdata}, 16'h0000);
        cyc(0, 8'h61, 0, 0, 0, 0, 0); check("R1 lo", {8'b0, cfg_rdata}, 16'h0060);
        cyc(0, 8'h70, 0, 0, 0, 0, 0); check("R1 irq", irq_out, 16'h0000);

        // R7: writes while inactive are trapped nowhere.
        cyc(1, 8'h70, 8'h21, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 16'h0060, 8'h11);
        cyc(0, 0, 0, 0, 1, 16'h0060, 0);
        // R2: reserved bits of the active register read 0.
        cyc(1, 8'h30, 8'hFF, 0, 0, 0, 0);
        cyc(0, 8'h30, 0, 0, 0, 0, 0);
        // R4: ignored offsets.
        for (int o = 1; o < 8; o++) if (o != 4) cyc(0, 0, 0, 1, 1, 16'h0060 + 16'(o), 8'hEE);
        // R10: write and read on port A together.
        cyc(0, 0, 0, 1, 0, 16'h0060, 8'hAB);
        cyc(0, 0, 0, 1, 1, 16'h0060, 8'hCD);
        cyc(0, 0, 0, 0, 1, 16'h0060, 0);
        // R9: shared line.
        cyc(1, 8'h70, 8'h55, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 16'h0064, 8'h01);
        cyc(0, 0, 0, 1, 0, 16'h0060, 8'h02);
        cyc(0, 0, 0, 0, 1, 16'h0064, 0);
        cyc(0, 0, 0, 0, 1, 16'h0060, 0);
        // R11: latch with nibble zero; R3: moved base window.
        cyc(1, 8'h70, 8'h30, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 16'h0060, 8'h77);
        cyc(0, 0, 0, 0, 1, 16'h0060, 0);
        cyc(1, 8'h60, 8'h02, 0, 0, 0, 0);
        cyc(1, 8'h61, 8'hFB, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 16'h02FC, 8'h99);
        cyc(0, 0, 0, 0, 1, 16'h02FC, 0);

        // Random traffic biased into the live window.
        for (int k = 0; k < 6000; k++) begin
            bit cwe = ($urandom % 100) < 8;
            logic [7:0] idx, cw;
            logic [15:0] a;
            case ($urandom % 5)
                0: idx = 8'h30; 1: idx = 8'h60; 2: idx = 8'h61;
                3: idx = 8'h70; default: idx = 8'($urandom);
            endcase
            cw = 8'($urandom);
            if (idx == 8'h30 && ($urandom % 4) != 0) cw[0] = 1'b1;
            if (idx == 8'h70 && ($urandom % 5) == 0) cw[7:4] = cw[3:0];
            if (($urandom % 10) < 8) a = {m_base[15:3], 3'($urandom)};
            else a = 16'($urandom);
            cyc(cwe, idx, cw, ($urandom % 10) < 4, ($urandom % 10) < 3, a, 8'($urandom));
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule